// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach PHY management registers over a two-wire serial pair: a clock (MDC) that the block generates, and a bidirectional data line (MDIO). Software sees four 32-bit words. Writing some of them starts a serial frame as a side effect, and software polls a busy flag until the frame has finished.

The block supports both framing variants. With the short variant (Clause 22), one frame carries a 5-bit register number together with the data. With the extended variant (Clause 45), an address frame first loads a 16-bit register address into the addressed device. A separate read or write frame then moves the data. A configuration field sets the MDC rate. A configuration bit moves outgoing data changes from the rising MDC edge to the falling MDC edge. Incoming data is always taken on the rising edge. If no device answers during a read turnaround, the block raises a read-error flag. That flag remains set until the next frame starts.

The MDIO pin is split into an output value, an output enable and a sampled input, so that a pad or a bench can combine them with a pull-up.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads back as zero, MDC is low and the MDIO output enable is low.
- R2: Word 0 (configuration) holds the extended-framing select in bit 6, the half-divide value in bits 15:8 and the falling-edge launch select in bit 23. Bit 0 (busy) and bit 1 (read error) are read-only. Word 1 (control) holds the device or register number in bits 4:0 and the port address in bits 9:5. Words 2 and 3 hold 16-bit data and address in bits 15:0. All other bits read as zero.
- R3: A write to word 2 in short mode sends 64 bits, MSB first, one per MDC rising edge: 32 ones, start 01, opcode 01, port[4:0], register[4:0], turnaround 10, data[15:0]. MDIO is driven for the whole frame.
- R4: A write to word 1 with bit 15 set starts a read frame, using the port and device fields from the same write. The opcode is 10 in short mode and 11 in extended mode. MDIO is released from the first turnaround bit onward. The 16 bits sampled at the last 16 rising edges land MSB first in word 2.
- R5: In extended mode a write to word 3 sends an address frame: start 00, opcode 00, port, device, turnaround 10, address[15:0]. In short mode a write to word 3 only stores the value and starts no frame.
- R6: In extended mode a write to word 2 sends start 00, opcode 01, port, device, turnaround 10, data.
- R7: Busy reads as 1 from the clock edge that accepts the starting write until the frame ends. A frame occupies exactly 128 MDC half periods. MDC stays low while the block is idle.
- R8: Each MDC half period lasts the configured half-divide value in system clocks. A value of 0 behaves as 1.
- R9: With bit 23 clear, driven MDIO changes only together with a rising MDC edge. With bit 23 set, it changes only together with a falling edge.
- R10: If MDIO reads 1 at the rising edge of the second turnaround bit of a read, the read-error bit is set. It is cleared when the next frame starts.
- R11: While busy, writes to every word are ignored and start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word index (0 config, 1 control, 2 data, 3 address) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the word selected by addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
Frames are captured bit by bit at the MDC rising edges and compared with frames assembled from the requirements. The captures cover a short-mode write, a short-mode read, and extended-mode address, write and read frames, so that each start and opcode pair is told apart from the others. Read frames are run once with a responder that answers with a known word and once with no responder and a pulled-up line. This separates data capture from error detection. Three half-divide values and both launch edges are exercised, and the frame length and MDC high time are measured at each setting. Writes issued while busy are checked at the register readback and at the busy flag.

// File: rtl/mdio_master.sv
module mdio_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int HDR_BITS = 46;
  localparam logic [6:0] TA2_IDX = 7'd47;

  logic        busy, rderr, ext, neg_launch, is_rd;
  logic [7:0]  div, hcnt;
  logic [4:0]  dev, port;
  logic [15:0] data, adr;
  logic [63:0] frame;
  logic [6:0]  rises, falls;

  wire [7:0] half = (div == 8'd0) ? 8'd1 : div;
  wire tick = busy && (hcnt == half - 8'd1);
  wire rise = tick && !mdc;
  wire fall = tick && mdc;

  wire [6:0] idx_raw = neg_launch ? falls : rises;
  wire [5:0] idx = idx_raw[6] ? 6'd63 : idx_raw[5:0];

  wire wr_ok = wr_en && !busy;
  wire go_rd = wr_ok && addr == 2'd1 && wdata[15];
  wire go_wr = wr_ok && addr == 2'd2;
  wire go_ad = wr_ok && addr == 2'd3 && ext;
  wire go    = go_rd || go_wr || go_ad;

  wire [1:0]  st  = ext ? 2'b00 : 2'b01;
  wire [1:0]  op  = go_rd ? (ext ? 2'b11 : 2'b10) : (go_wr ? 2'b01 : 2'b00);
  wire [4:0]  fp  = go_rd ? wdata[9:5] : port;
  wire [4:0]  fd  = go_rd ? wdata[4:0] : dev;
  wire [15:0] fdat = go_rd ? 16'hFFFF : wdata[15:0];

  assign mdio_o  = busy ? frame[6'd63 - idx] : 1'b1;
  assign mdio_oe = busy && (!is_rd || idx < 6'(HDR_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; rderr <= 1'b0; ext <= 1'b0; neg_launch <= 1'b0; is_rd <= 1'b0;
      div <= '0; hcnt <= '0; dev <= '0; port <= '0; data <= '0; adr <= '0;
      frame <= '0; rises <= '0; falls <= '0; mdc <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (addr)
          2'd0: begin ext <= wdata[6]; div <= wdata[15:8]; neg_launch <= wdata[23]; end
          2'd1: begin dev <= wdata[4:0]; port <= wdata[9:5]; end
          2'd2: data <= wdata[15:0];
          default: adr <= wdata[15:0];
        endcase
      end
      if (go) begin
        busy  <= 1'b1;
        rderr <= 1'b0;
        is_rd <= go_rd;
        frame <= {32'hFFFF_FFFF, st, op, fp, fd, 2'b10, fdat};
        hcnt  <= '0;
        rises <= '0;
        falls <= '0;
        mdc   <= 1'b0;
      end else if (busy) begin
        if (tick) begin
          hcnt <= '0;
          mdc  <= !mdc;
        end else begin
          hcnt <= hcnt + 8'd1;
        end
        if (rise) begin
          rises <= rises + 7'd1;
          if (is_rd && rises == TA2_IDX) rderr <= mdio_i;
          if (is_rd && rises > TA2_IDX) data <= {data[14:0], mdio_i};
        end
        if (fall) begin
          falls <= falls + 7'd1;
          if (falls == 7'd63) busy <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {8'd0, neg_launch, 7'd0, div, 1'b0, ext, 4'd0, rderr, busy};
      2'd1:    rdata = {22'd0, port, dev};
      2'd2:    rdata = {16'd0, data};
      default: rdata = {16'd0, adr};
    endcase
  end

  assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  assert_drive_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  assert_start_preamble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdio_oe && mdio_o));
  assert_rderr_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !rderr);
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(div) && $stable(ext) && $stable(neg_launch)));
  assert_read_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd && rises > TA2_IDX) |-> !mdio_oe);

endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  wire [31:0] rdata;
  wire mdc, mdio_o, mdio_oe;
  wire mdio_line;
  logic phy_en = 1'b0;
  logic [15:0] phy_data = '0;
  logic [6:0] rc = '0;
  logic [63:0] cap = '0;
  logic prev_mdc = 1'b0, prev_line = 1'b1, prev_oe = 1'b0;
  int hi_cnt = 0, hi_len = 0, rise_chg = 0, fall_chg = 0;
  int checks = 0, errors = 0;
  logic phy_bit;

  always #5 clk = ~clk;

  always_comb phy_bit = (phy_en && rc >= 7'd47 && rc <= 7'd63) ?
                        ((rc == 7'd47) ? 1'b0 : phy_data[63 - rc]) : 1'b1;
  assign mdio_line = mdio_oe ? mdio_o : phy_bit;

  mdio_master uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                   .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line));

  always @(negedge clk) begin
    if (mdio_oe && !prev_oe) begin
      rc <= '0;
      cap <= '0;
    end else if (mdc && !prev_mdc) begin
      cap <= {cap[62:0], prev_line};
      rc <= rc + 7'd1;
    end
    if (mdc && !prev_mdc) begin
      hi_cnt <= 1;
      if (mdio_oe && prev_oe && mdio_line !== prev_line) rise_chg <= rise_chg + 1;
    end else if (mdc) hi_cnt <= hi_cnt + 1;
    if (!mdc && prev_mdc) begin
      hi_len <= hi_cnt;
      if (mdio_oe && prev_oe && mdio_line !== prev_line) fall_chg <= fall_chg + 1;
    end
    prev_mdc <= mdc; prev_line <= mdio_line; prev_oe <= mdio_oe;
  end

  function automatic logic [63:0] fr(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] p, input logic [4:0] d, input logic [15:0] v);
    return {32'hFFFF_FFFF, st, op, p, d, 2'b10, v};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0; addr = 2'd0; #1;
    while (rdata[0] && n < 100000) begin
      n++; @(negedge clk); #1;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v); chk("R1 reg", v, 0);
    end
    chk("R1 mdc", mdc, 0);
    chk("R1 oe", mdio_oe, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(0, 32'hFF80_AB43); rd(0, v); chk("R2 cfg", v, 32'h0080_AB40);
    wr(1, 32'h0000_73FF); rd(1, v); chk("R2 ctl", v, 32'h0000_03FF);
    rd(0, v); chk("R2 ctl no start", v[0], 0);
    wr(0, 32'h0000_0200);
  endtask

  task automatic t_c22_write;
    logic [31:0] v; int n;
    wr(1, {22'd0, 5'd5, 5'h11});
    rise_chg = 0; fall_chg = 0;
    wr(2, 32'h0000_A5C3);
    rd(0, v); chk("R7 busy", v[0], 1);
    wait_idle(n);
    chk("R7 len", n, 256);
    chk("R8 half", hi_len, 2);
    chk("R3 frame", cap, fr(2'b01, 2'b01, 5'd5, 5'h11, 16'hA5C3));
    chk("R9 rising launch", fall_chg, 0);
    chk("R7 mdc idle", mdc, 0);
  endtask

  task automatic t_c22_read;
    logic [31:0] v; int n;
    phy_en = 1'b1; phy_data = 16'h1234;
    wr(1, 32'h8000 | {22'd0, 5'd3, 5'd2});
    wait_idle(n);
    chk("R4 frame", cap, fr(2'b01, 2'b10, 5'd3, 5'd2, 16'h1234));
    rd(2, v); chk("R4 data", v, 32'h1234);
    rd(0, v); chk("R10 no error", v[1], 0);
  endtask

  task automatic t_c45;
    logic [31:0] v; int n;
    wr(0, 32'h0000_0240);
    wr(1, {22'd0, 5'd7, 5'd1});
    wr(3, 32'h0000_BEEF); wait_idle(n);
    chk("R5 addr frame", cap, fr(2'b00, 2'b00, 5'd7, 5'd1, 16'hBEEF));
    wr(2, 32'h0000_0F0F); wait_idle(n);
    chk("R6 write frame", cap, fr(2'b00, 2'b01, 5'd7, 5'd1, 16'h0F0F));
    wr(0, 32'h0080_0340);
    phy_en = 1'b1; phy_data = 16'hCAFE; rise_chg = 0;
    wr(1, 32'h8000 | {22'd0, 5'd7, 5'd1}); wait_idle(n);
    chk("R4 ext read frame", cap, fr(2'b00, 2'b11, 5'd7, 5'd1, 16'hCAFE));
    rd(2, v); chk("R4 ext data", v, 32'hCAFE);
    chk("R9 falling launch", rise_chg, 0);
    chk("R8 half 3", hi_len, 3);
    chk("R8 len 3", n, 384);
  endtask

  task automatic t_c22_addr;
    logic [31:0] v;
    wr(0, 32'h0000_0200);
    wr(3, 32'h0000_1111);
    rd(0, v); chk("R5 short no start", v[0], 0);
    rd(3, v); chk("R5 stored", v, 32'h1111);
  endtask

  task automatic t_rderr;
    logic [31:0] v; int n;
    phy_en = 1'b0;
    wr(1, 32'h8000 | {22'd0, 5'd9, 5'd4}); wait_idle(n);
    rd(0, v); chk("R10 set", v[1], 1);
    rd(2, v); chk("R10 data ones", v, 32'hFFFF);
    wr(2, 32'h0000_0001);
    rd(0, v); chk("R10 cleared at start", v[1:0], 2'b01);
    wait_idle(n);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v; int n;
    wr(2, 32'h0000_5555);
    wr(2, 32'h0000_9999);
    wr(0, 32'h0080_0F40);
    wr(1, 32'h0000_8000);
    wait_idle(n);
    rd(2, v); chk("R11 data kept", v, 32'h5555);
    rd(0, v); chk("R11 cfg kept", v, 32'h0000_0200);
    @(negedge clk); rd(0, v); chk("R11 no extra frame", v[0], 0);
    chk("R11 frame", cap, fr(2'b01, 2'b01, 5'd9, 5'd4, 16'h5555));
  endtask

  task automatic t_div0;
    int n;
    wr(0, 32'h0);
    wr(2, 32'h0000_00AA); wait_idle(n);
    chk("R8 zero len", n, 128);
    chk("R8 zero half", hi_len, 1);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_c22_write();
    t_c22_read();
    t_c45();
    t_c22_addr();
    t_rderr();
    t_busy_ignore();
    t_div0();
    finish_run();
  end
endmodule